// File: doc/BRIEF.md
# Integer-Division Baud Tick Generator

This block derives the timing strobes for an asynchronous serial port from one system clock. It divides that clock by a programmable whole number, so only discrete bit rates can be produced. A 16-bit divisor sets the prescale. The clock is divided by the divisor plus one, which gives an oversampling strobe. A second strobe marks each bit period. It fires once per 16 oversampling strobes in the normal rate mode and once per 8 in the double-speed mode. The double-speed mode lets a slow clock reach common baud rates more closely. For example, with a 1 MHz clock, divisor 12 in double-speed mode gives 1,000,000/(8·13) ≈ 9615 baud. In normal mode, divisor 5 gives 1,000,000/(16·6) ≈ 10417 baud.

Software loads the divisor one byte at a time over a shared byte bus. The upper byte is held until the lower byte arrives. The complete value is then applied in a single step and the count starts again. The shift registers, framing and parity of the serial port are outside this block. Those parts only consume the two strobes.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high at a clock edge, both strobes are low after that edge. After reset the divisor is 0, the mode is normal and all counters are zero.
- R2: `os_tick` is a one-clock pulse repeating every divisor+1 clocks.
- R3: In normal mode (`dbl_mode`=0), `bit_tick` is a one-clock pulse that coincides with every 16th `os_tick`. Its spacing is 16·(divisor+1) clocks.
- R4: In double-speed mode (`dbl_mode`=1), `bit_tick` coincides with every 8th `os_tick`. Its spacing is 8·(divisor+1) clocks.
- R5: A write with `div_hi_we` only stores `wr_byte` as the pending upper byte. The active divisor and the strobe spacing do not change.
- R6: A write with `div_lo_we` sets the divisor to {pending upper byte, `wr_byte`} and clears both counters. The first `os_tick` then comes divisor+1 clocks after the write edge, and the first `bit_tick` comes after one full bit period.
- R7: Any change of `dbl_mode` clears both counters. The first bit period after the change is full length in the new mode.
- R8: While `en` is low, both strobes stay low and both counters hold their value. When `en` returns high, the count resumes where it stopped.
- R9: A divisor of 0 gives an `os_tick` on every clock cycle.
- R10: A divisor of 65535 gives an `os_tick` spacing of 65536 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; low freezes counters and silences strobes |
| dbl_mode | input | 1 | 0 = 16x oversampling, 1 = 8x oversampling |
| div_hi_we | input | 1 | Store `wr_byte` as pending upper divisor byte |
| div_lo_we | input | 1 | Apply divisor {pending, `wr_byte`} and restart |
| wr_byte | input | 8 | Divisor byte data |
| os_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | Bit-period strobe |

## Verification
The hardest case to reach is the largest divisor, 65535. A full bit period at that setting lasts about a million clocks, so the stimulus checks only the oversampling spacing there, measured from the restart caused by the low-byte write. The mid-period mode switch and the enable pause are placed at known points just after a strobe. This makes the expected count until the next strobe exact.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    RATE_X16 = 1'b0,
    RATE_X8  = 1'b1
  } rate_mode_e;
endpackage

// File: rtl/baud_div_reg.sv
module baud_div_reg #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = DIV_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hi_we,
  input  logic              lo_we,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [DIV_W-1:0]  div_q
);
  localparam int HI_W = DIV_W - BYTE_W;

  logic [HI_W-1:0] hi_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pend <= '0;
      div_q   <= '0;
    end else begin
      if (hi_we) hi_pend <= wr_byte[HI_W-1:0];
      if (lo_we) div_q   <= {hi_pend, wr_byte};
    end
  end

  p_hi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (hi_we && !lo_we) |=> $stable(div_q));
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_q,
  output logic             os_pulse,
  output logic             os_tick
);
  logic [DIV_W-1:0] cnt;
  logic             hit;

  assign hit      = (cnt == div_q);
  assign os_pulse = en && !restart && hit;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt     <= '0;
      os_tick <= 1'b0;
    end else if (en) begin
      cnt     <= hit ? '0 : cnt + 1'b1;
      os_tick <= hit;
    end else begin
      os_tick <= 1'b0;
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst)
    cnt <= div_q);
  p_restart_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    restart |=> !os_tick);
endmodule

// File: rtl/baud_bit_ctr.sv
module baud_bit_ctr
  import baud_pkg::*;
#(
  parameter int NORM_OSR = 16,
  parameter int DBL_OSR  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       os_pulse,
  input  rate_mode_e mode_q,
  output logic       bit_tick
);
  localparam int CNT_W = $clog2(NORM_OSR);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(NORM_OSR - 1);
  localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DBL_OSR - 1);

  logic [CNT_W-1:0] bcnt;
  logic [CNT_W-1:0] last;

  assign last = (mode_q == RATE_X8) ? LAST_D : LAST_N;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      bcnt     <= '0;
      bit_tick <= 1'b0;
    end else begin
      bit_tick <= 1'b0;
      if (os_pulse) begin
        if (bcnt == last) begin
          bcnt     <= '0;
          bit_tick <= 1'b1;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  p_bcnt_range_r4: assert property (@(posedge clk) disable iff (rst)
    bcnt <= last);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int NORM_OSR = 16,
  parameter int DBL_OSR  = 8,
  localparam int BYTE_W  = DIV_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              dbl_mode,
  input  logic              div_hi_we,
  input  logic              div_lo_we,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              os_tick,
  output logic              bit_tick
);
  rate_mode_e       mode_q;
  rate_mode_e       mode_in;
  logic             mode_chg;
  logic             restart;
  logic             os_pulse;
  logic [DIV_W-1:0] div_q;

  assign mode_in  = rate_mode_e'(dbl_mode);
  assign mode_chg = (mode_in != mode_q);
  assign restart  = div_lo_we || mode_chg;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= RATE_X16;
    else     mode_q <= mode_in;
  end

  baud_div_reg #(.DIV_W(DIV_W), .BYTE_W(BYTE_W)) u_div (
    .clk(clk), .rst(rst), .hi_we(div_hi_we), .lo_we(div_lo_we),
    .wr_byte(wr_byte), .div_q(div_q)
  );

  baud_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .en(en), .restart(restart), .div_q(div_q),
    .os_pulse(os_pulse), .os_tick(os_tick)
  );

  baud_bit_ctr #(.NORM_OSR(NORM_OSR), .DBL_OSR(DBL_OSR)) u_bit (
    .clk(clk), .rst(rst), .restart(restart), .os_pulse(os_pulse),
    .mode_q(mode_q), .bit_tick(bit_tick)
  );

  p_bit_on_os_r3: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> os_tick);
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!os_tick && !bit_tick));
  p_mode_restart_r7: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !bit_tick);
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic       dbl_mode = 1'b0;
  logic       div_hi_we = 1'b0;
  logic       div_lo_we = 1'b0;
  logic [7:0] wr_byte = '0;
  logic       os_tick, bit_tick;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rst(rst), .en(en), .dbl_mode(dbl_mode),
    .div_hi_we(div_hi_we), .div_lo_we(div_lo_we), .wr_byte(wr_byte),
    .os_tick(os_tick), .bit_tick(bit_tick)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_os(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!os_tick && n < 150000);
  endtask

  task automatic wait_bit(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!bit_tick && n < 150000);
  endtask

  // ends at the negedge just after the restart edge
  task automatic write_div(int v);
    @(negedge clk); div_hi_we = 1'b1; wr_byte = v[15:8];
    @(negedge clk); div_hi_we = 1'b0; div_lo_we = 1'b1; wr_byte = v[7:0];
    @(negedge clk); div_lo_we = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 os low in reset", int'(os_tick), 0);
    check("R1 bit low in reset", int'(bit_tick), 0);
    rst = 1'b0;
    wait_os(n);  check("R1/R9 first os after reset", n, 1);
    wait_os(n);  check("R9 os spacing div0", n, 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    wait_bit(n); check("R1/R3 first bit after reset", n, 16);
    wait_bit(n); check("R3 bit spacing div0", n, 16);
  endtask

  task automatic t_rate(int dv, bit dbl, bit do_bit, string tag);
    int n, osr;
    osr = dbl ? 8 : 16;
    @(negedge clk); dbl_mode = dbl;
    write_div(dv);
    wait_os(n); check({tag, " R6 first os"}, n, dv + 1);
    wait_os(n); check({tag, " R2 os spacing"}, n, dv + 1);
    if (do_bit) begin
      write_div(dv);
      wait_bit(n); check({tag, dbl ? " R4 first bit" : " R3 first bit"}, n, osr * (dv + 1));
      wait_bit(n); check({tag, dbl ? " R4 bit spacing" : " R3 bit spacing"}, n, osr * (dv + 1));
    end
  endtask

  task automatic t_hi_hold();
    int n;
    @(negedge clk); dbl_mode = 1'b0;
    write_div(5);
    wait_os(n);
    @(negedge clk); div_hi_we = 1'b1; wr_byte = 8'h01;
    @(negedge clk); div_hi_we = 1'b0;
    wait_os(n); wait_os(n); check("R5 spacing kept after high write", n, 6);
    @(negedge clk); div_lo_we = 1'b1; wr_byte = 8'h02;
    @(negedge clk); div_lo_we = 1'b0;
    wait_os(n); check("R5/R6 held high byte applied", n, 259);
  endtask

  task automatic t_mode_switch();
    int n;
    @(negedge clk); dbl_mode = 1'b0;
    write_div(2);
    repeat (5) wait_os(n);
    @(negedge clk); dbl_mode = 1'b1;
    @(negedge clk);
    wait_bit(n); check("R7 full bit period after switch to x8", n, 24);
    @(negedge clk); dbl_mode = 1'b0;
    @(negedge clk);
    wait_bit(n); check("R7 full bit period after switch to x16", n, 48);
  endtask

  task automatic t_enable();
    int n, seen;
    @(negedge clk); dbl_mode = 1'b0;
    write_div(3);
    wait_os(n);
    en = 1'b0;
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (os_tick || bit_tick) seen++;
    end
    check("R8 strobes silent while disabled", seen, 0);
    en = 1'b1;
    wait_os(n); check("R8 count resumes where held", n, 4);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rate(0, 1'b1, 1'b1, "div0 x8 R9");
    t_rate(12, 1'b1, 1'b1, "div12 x8");
    t_rate(5, 1'b0, 1'b1, "div5 x16");
    t_rate(12, 1'b0, 1'b1, "div12 x16");
    t_hi_hold();
    t_mode_switch();
    t_enable();
    t_rate(65535, 1'b0, 1'b0, "div65535 R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule